// File: doc/BRIEF.md
# Data Window Address Translator

This block turns a 16-bit logical data address into a physical location by looking it up in a small bank of map registers. The logical space is cut into four equal windows of 16 KB. The top two address bits pick a window, and that window's map register decides where the access lands. A window can point into unified memory, into instruction memory or into on-chip data memory, each at a chosen segment. It can also be switched to I/O mode. In I/O mode every 4 KB quarter of the window draws its I/O segment from its own nibble of the map register.

The map registers are written and read through a register port that decodes byte addresses in the on-chip register page. Map register 2 also answers at a second address, so either address reaches the same storage. A translation request returns its result one clock later. The result is either a strobe with the target space, the physical offset and a byte count clipped at the window edge, or a single-cycle fault when the window selects the reserved space.

Top module: `dwt_window_xlat`

## Requirements
- R1: After reset, map registers 0, 1 and 2 read 0x2000 and map register 3 reads 0x0000. With the `LEGACY_RESET` parameter set, register 2 resets to 0x0000 instead.
- R2: Map register n is read and written at byte address 0xFF08 + 2*n. A write to any other address changes no register, and a read of an address that decodes to nothing returns 0.
- R3: Address 0xFF04 is a second address for map register 2 (0xFF0C). A write through either address is seen on a read through the other.
- R4: Logical address bits 15:14 select the map register, and bits 13:0 form the window offset.
- R5: When map bit 15 is 0 and map bits 13:12 are 00, `xl_space` is 0 (unified) and `xl_phys` is segment*0x4000 + offset. The segment is map bits 9:0, and map bits 11:10 and 14 have no effect.
- R6: When map bit 15 is 0 and map bits 13:12 are 01, `xl_space` is 1 (instruction) and `xl_phys` is segment*0x4000 + offset.
- R7: When map bit 15 is 0 and map bits 13:12 are 10, `xl_space` is 2 (on-chip data) and `xl_phys` is (segment << 16) + window index*0x4000 + offset.
- R8: When map bit 15 is 0 and map bits 13:12 are 11, `xl_fault` pulses for one cycle and `xl_strobe` stays low.
- R9: When map bit 15 is 1, `xl_space` is 3 (I/O) whatever bits 13:12 hold. Offset bits 13:12 = k select nibble k counted from the most significant nibble of the map register, and `xl_phys` is nibble*0x10000 + 0xC000 + offset.
- R10: `xl_len` is the smaller of `xl_nbytes` and 0x4000 minus the offset.
- R11: A request produces exactly one of `xl_strobe` or `xl_fault` on the cycle after it, and a cycle without a request produces neither.
- R12: A request in the same cycle as a map register write is translated with the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register page write enable |
| reg_addr | input | 16 | Register page byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| xl_req | input | 1 | Translation request |
| xl_laddr | input | 16 | Logical data address |
| xl_nbytes | input | 4 | Requested access length in bytes |
| xl_strobe | output | 1 | Valid translation, one cycle after request |
| xl_fault | output | 1 | Bus fault, one cycle after request |
| xl_space | output | 2 | Target space: 0 unified, 1 instruction, 2 data, 3 I/O |
| xl_phys | output | 26 | Physical offset within the target space |
| xl_len | output | 4 | Bytes allowed before the window edge |

## Verification
The bench builds the block with its default parameters: four 16 KB windows, 10-bit segments and `LEGACY_RESET` cleared. With these values every window index and the largest segment can be reached from 16-bit map values, the full 26-bit data-space offset can be produced, and the clip can be driven to its last byte with a 4-bit length. Because the bench uses the default reset, it checks the normal reset values; the legacy reset value of register 2 is only reachable with the parameter set.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_MAPS  = 4;
    localparam int IDX_W     = $clog2(NUM_MAPS);
    localparam int LADDR_W   = 16;
    localparam int WIN_BITS  = LADDR_W - IDX_W;
    localparam int REM_W     = WIN_BITS + 1;
    localparam int SEG_W     = 10;
    localparam int NB_W      = 4;
    localparam int PHYS_W    = SEG_W + IDX_W + WIN_BITS;
    localparam int IO_BIT    = 15;
    localparam int SPACE_LSB = 12;
    localparam int NIB_LSB   = 12;

    localparam logic [WORD_W-1:0] MAP_BASE   = 16'hFF08;
    localparam logic [WORD_W-1:0] ALIAS_ADDR = 16'hFF04;
    localparam int                ALIAS_IDX  = 2;
    localparam logic [15:0]       IO_BASE    = 16'hC000;

    typedef enum logic [1:0] {
        SP_UNIF = 2'd0,
        SP_INSN = 2'd1,
        SP_DATA = 2'd2,
        SP_IO   = 2'd3
    } space_e;

    typedef struct packed {
        logic              fault;
        space_e            space;
        logic [PHYS_W-1:0] phys;
        logic [NB_W-1:0]   len;
    } xl_res_t;

    function automatic logic [3:0] pick_nibble(input logic [WORD_W-1:0] m,
                                               input logic [1:0] sel);
        case (sel)
            2'd0:    return m[15:12];
            2'd1:    return m[11:8];
            2'd2:    return m[7:4];
            default: return m[3:0];
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] map_reset(input int n, input bit legacy);
        case (n)
            0, 1:    return 16'h2000;
            2:       return legacy ? 16'h0000 : 16'h2000;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/dwt_map_regs.sv
module dwt_map_regs
    import dwt_pkg::*;
#(
    parameter bit LEGACY_RESET = 1'b0
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr,
    input  logic [WORD_W-1:0]                addr,
    input  logic [WORD_W-1:0]                wdata,
    output logic [WORD_W-1:0]                rdata,
    output logic [NUM_MAPS-1:0][WORD_W-1:0]  maps
);

    logic [NUM_MAPS-1:0] hit;

    for (genvar i = 0; i < NUM_MAPS; i++) begin : g_map
        localparam logic [WORD_W-1:0] MY_ADDR = WORD_W'(MAP_BASE + 2 * i);
        if (i == ALIAS_IDX) begin : g_alias
            assign hit[i] = (addr == MY_ADDR) || (addr == ALIAS_ADDR);
        end else begin : g_plain
            assign hit[i] = (addr == MY_ADDR);
        end

        always_ff @(posedge clk) begin
            if (rst)
                maps[i] <= map_reset(i, LEGACY_RESET);
            else if (wr && hit[i])
                maps[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_MAPS; i++)
            if (hit[i]) rdata = rdata | maps[i];
    end

endmodule

// File: rtl/dwt_xlate.sv
module dwt_xlate
    import dwt_pkg::*;
(
    input  logic [NUM_MAPS-1:0][WORD_W-1:0] maps,
    input  logic [LADDR_W-1:0]              laddr,
    input  logic [NB_W-1:0]                 nbytes,
    output xl_res_t                         res
);

    logic [IDX_W-1:0]    idx;
    logic [WIN_BITS-1:0] off;
    logic [WORD_W-1:0]   map;
    logic [SEG_W-1:0]    seg;
    logic [REM_W-1:0]    remain;
    logic [3:0]          nib;
    logic [15:0]         io_low;
    logic                unused_map_bits;

    assign idx    = laddr[LADDR_W-1 -: IDX_W];
    assign off    = laddr[WIN_BITS-1:0];
    assign map    = maps[idx];
    assign seg    = map[SEG_W-1:0];
    assign remain = REM_W'(1 << WIN_BITS) - {1'b0, off};
    assign nib    = pick_nibble(map, off[NIB_LSB +: 2]);
    assign io_low = 16'(IO_BASE + 16'(off));
    assign unused_map_bits = ^{map[14], map[11:SEG_W]};

    always_comb begin
        res = '0;
        res.len = (REM_W'(nbytes) > remain) ? NB_W'(remain) : nbytes;
        if (map[IO_BIT]) begin
            res.space = SP_IO;
            res.phys  = PHYS_W'({nib, io_low});
        end else begin
            case (map[SPACE_LSB +: 2])
                2'b00: begin
                    res.space = SP_UNIF;
                    res.phys  = PHYS_W'({seg, off});
                end
                2'b01: begin
                    res.space = SP_INSN;
                    res.phys  = PHYS_W'({seg, off});
                end
                2'b10: begin
                    res.space = SP_DATA;
                    res.phys  = {seg, idx, off};
                end
                default: begin
                    res.fault = 1'b1;
                    res.len   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dwt_window_xlat.sv
module dwt_window_xlat
    import dwt_pkg::*;
#(
    parameter bit LEGACY_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [15:0]       reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              xl_req,
    input  logic [15:0]       xl_laddr,
    input  logic [3:0]        xl_nbytes,
    output logic              xl_strobe,
    output logic              xl_fault,
    output logic [1:0]        xl_space,
    output logic [25:0]       xl_phys,
    output logic [3:0]        xl_len
);

    logic [NUM_MAPS-1:0][WORD_W-1:0] maps;
    xl_res_t                         res;

    dwt_map_regs #(.LEGACY_RESET(LEGACY_RESET)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .maps  (maps)
    );

    dwt_xlate u_xlate (
        .maps   (maps),
        .laddr  (xl_laddr),
        .nbytes (xl_nbytes),
        .res    (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_strobe <= 1'b0;
            xl_fault  <= 1'b0;
            xl_space  <= '0;
            xl_phys   <= '0;
            xl_len    <= '0;
        end else begin
            xl_strobe <= xl_req && !res.fault;
            xl_fault  <= xl_req && res.fault;
            if (xl_req) begin
                xl_space <= res.space;
                xl_phys  <= res.phys;
                xl_len   <= res.len;
            end
        end
    end

endmodule

// File: rtl/dwt_window_xlat_chk.sv
module dwt_window_xlat_chk (
    input logic        clk,
    input logic        rst,
    input logic        xl_req,
    input logic [3:0]  xl_nbytes,
    input logic        xl_strobe,
    input logic        xl_fault,
    input logic [1:0]  xl_space,
    input logic [25:0] xl_phys,
    input logic [3:0]  xl_len
);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(xl_strobe && xl_fault));

    a_r11_answer: assert property (@(posedge clk) disable iff (rst)
        xl_req |=> (xl_strobe || xl_fault));

    a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
        !xl_req |=> !(xl_strobe || xl_fault));

    a_r10_clip: assert property (@(posedge clk) disable iff (rst)
        xl_req |=> (!xl_strobe || xl_len <= $past(xl_nbytes)));

    a_r9_io_range: assert property (@(posedge clk) disable iff (rst)
        (xl_strobe && xl_space == 2'd3) |-> (xl_phys[15:14] == 2'b11));

endmodule

bind dwt_window_xlat dwt_window_xlat_chk u_chk (.*);

// File: tb/dwt_window_xlat_test.sv
`timescale 1ns/1ps
module dwt_window_xlat_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        xl_req = 1'b0;
    logic [15:0] xl_laddr = '0;
    logic [3:0]  xl_nbytes = '0;
    logic        xl_strobe, xl_fault;
    logic [1:0]  xl_space;
    logic [25:0] xl_phys;
    logic [3:0]  xl_len;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dwt_window_xlat uut (.*);

    typedef struct packed {
        logic [15:0] map;
        logic [15:0] laddr;
        logic [3:0]  nb;
        logic [1:0]  space;
        logic [25:0] phys;
        logic [3:0]  len;
        logic        fault;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{16'h0005, 16'h1234, 4'd4,  2'd0, 26'h0015234, 4'd4,  1'b0}, // R5
        '{16'h1003, 16'h4010, 4'd2,  2'd1, 26'h000C010, 4'd2,  1'b0}, // R6
        '{16'h2007, 16'h8100, 4'd8,  2'd2, 26'h0078100, 4'd8,  1'b0}, // R7
        '{16'h3000, 16'hC000, 4'd1,  2'd0, 26'h0000000, 4'd0,  1'b1}, // R8
        '{16'h9ABC, 16'h3020, 4'd2,  2'd3, 26'h00CF020, 4'd2,  1'b0}, // R9 nibble 3
        '{16'h8123, 16'h4005, 4'd1,  2'd3, 26'h008C005, 4'd1,  1'b0}, // R9 nibble 0
        '{16'hB000, 16'hD800, 4'd3,  2'd3, 26'h000D800, 4'd3,  1'b0}, // R9 over bits 13:12=11
        '{16'h0000, 16'h3FFE, 4'd8,  2'd0, 26'h0003FFE, 4'd2,  1'b0}, // R10 clipped
        '{16'h1001, 16'h7FF8, 4'd8,  2'd1, 26'h0007FF8, 4'd8,  1'b0}, // R10 exact fit
        '{16'h23FF, 16'hBFFF, 4'd15, 2'd2, 26'h3FFBFFF, 4'd1,  1'b0}, // R7 R10 top
        '{16'h4FFF, 16'h0000, 4'd1,  2'd0, 26'h0FFC000, 4'd1,  1'b0}  // R5 bits 14,11:10 ignored
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic xlate(input logic [15:0] la, input logic [3:0] nb);
        xl_req = 1'b1; xl_laddr = la; xl_nbytes = nb;
        @(negedge clk);
        xl_req = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd_reg(16'hFF08, d); check("R1 map0", d, 16'h2000);
        rd_reg(16'hFF0A, d); check("R1 map1", d, 16'h2000);
        rd_reg(16'hFF0C, d); check("R1 map2", d, 16'h2000);
        rd_reg(16'hFF0E, d); check("R1 map3", d, 16'h0000);
        check("R11 idle strobe", {xl_strobe, xl_fault}, 2'b00);

        // R3: alias both ways
        @(negedge clk);
        wr_reg(16'hFF04, 16'h1234);
        rd_reg(16'hFF0C, d); check("R3 alias write seen", d, 16'h1234);
        @(negedge clk);
        wr_reg(16'hFF0C, 16'h0ABC);
        rd_reg(16'hFF04, d); check("R3 alias read", d, 16'h0ABC);

        // R2: non-register addresses have no effect
        @(negedge clk);
        wr_reg(16'hFF06, 16'hFFFF);
        wr_reg(16'hFF09, 16'hFFFF);
        rd_reg(16'hFF06, d); check("R2 unmapped read", d, 16'h0000);
        rd_reg(16'hFF08, d); check("R2 map0 untouched", d, 16'h2000);
        rd_reg(16'hFF0A, d); check("R2 map1 untouched", d, 16'h2000);
        rd_reg(16'hFF0C, d); check("R2 map2 untouched", d, 16'h0ABC);
        rd_reg(16'hFF0E, d); check("R2 map3 untouched", d, 16'h0000);
        @(negedge clk);

        // Vector table: R4 window select by writing the indexed register
        for (int k = 0; k < NV; k++) begin
            wr_reg(16'hFF08 + 16'(2 * VECS[k].laddr[15:14]), VECS[k].map);
            xlate(VECS[k].laddr, VECS[k].nb);
            check($sformatf("R4 vec%0d fault", k), xl_fault, VECS[k].fault);
            check($sformatf("R11 vec%0d strobe", k), xl_strobe, !VECS[k].fault);
            if (!VECS[k].fault) begin
                check($sformatf("R4 vec%0d space", k), xl_space, VECS[k].space);
                check($sformatf("R4 vec%0d phys", k), xl_phys, VECS[k].phys);
                check($sformatf("R10 vec%0d len", k), xl_len, VECS[k].len);
            end
        end

        // R8 / R11: fault is one cycle only
        wr_reg(16'hFF0E, 16'h3000);
        xlate(16'hC123, 4'd2);
        check("R8 fault pulse", {xl_strobe, xl_fault}, 2'b01);
        @(negedge clk);
        check("R8 fault drops", {xl_strobe, xl_fault}, 2'b00);

        // R12: write and request in the same cycle
        wr_reg(16'hFF0C, 16'h2001);
        reg_wr = 1'b1; reg_addr = 16'hFF0C; reg_wdata = 16'h2002;
        xl_req = 1'b1; xl_laddr = 16'h8000; xl_nbytes = 4'd1;
        @(negedge clk);
        reg_wr = 1'b0; xl_req = 1'b0;
        check("R12 old value used", xl_phys, 26'h0018000);
        xlate(16'h8000, 4'd1);
        check("R12 new value next", xl_phys, 26'h0028000);
        check("R7 space data", xl_space, 2'd2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule